// File: doc/BRIEF.md
# Serial Control and Diagnosis Slave

This block is a 16-bit serial slave with a shift register. It receives a control word from a host and returns a diagnosis word at the same time. The host selects the slave by pulling the active-low select line low. At that moment the slave copies its parallel diagnosis input into the shift register, and the most significant bit appears on the data output at once. Each rising edge of the serial clock samples the data input. Each falling edge shifts the register by one place, so the next bit reaches the output. When the select line returns high, the contents of the shift register become the new control word. While the slave is not selected, its data output enable stays low.

The data path is one 16-bit shift register, so bits that enter on the data input come out of the data output 16 clocks later. Because of this, several slaves can be chained output to input in a daisy chain. A host that transfers in bytes can send two 8-bit bursts under a single selection. All three serial inputs are resynchronised to the system clock and their edges are found in that domain. A separate input tells the block to put the control word back to its default value.

The sequencer has three states. IDLE (deselected) goes to SHIFT on a falling select edge, which also loads the diagnosis word. SHIFT (selected) goes to COMMIT on a rising select edge. COMMIT writes the control word and then goes back to IDLE. If a new falling select edge arrives during COMMIT, the block goes straight to SHIFT and loads again.

Top module: `spi_ctl_slave`

## Requirements
- R1: After reset, ctrl_word equals CTRL_DEFAULT (16'h0100) and spi_miso_oe is 0.
- R2: spi_miso_oe is 0 whenever the synchronised select input has been high for two consecutive system clocks, and it is 1 throughout a selected frame.
- R3: On the falling edge of spi_cs_n, diag_word is captured. Before the first serial clock edge, spi_miso shows diag_word[15], and the following bits come out most significant first.
- R4: spi_mosi is sampled on the rising edge of spi_sclk, and the shift register moves on the falling edge. After the k-th falling edge, spi_miso shows transmitted bit k (counting from 0).
- R5: When spi_cs_n rises after exactly 16 clocks, ctrl_word takes the received word, with the first bit received ending up in bit 15.
- R6: While a frame is in progress, ctrl_word keeps its previous value until spi_cs_n rises.
- R7: In a frame of 32 clocks, spi_miso outputs the first 16 received bits during clocks 16 to 31, and ctrl_word takes the last 16 bits received.
- R8: Two 8-bit bursts separated by a pause with spi_sclk held low, all under one selection, give the same output stream and the same control word as one 16-bit burst.
- R9: If defaults_req is high at a clock edge, ctrl_word is CTRL_DEFAULT after that edge. This takes priority over a commit in the same cycle.
- R10: A change on diag_word after the falling select edge has no effect on the bits sent on spi_miso in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| defaults_req | input | 1 | Restore the control word to its default value |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data input |
| spi_miso | output | 1 | Serial data output |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| diag_word | input | 16 | Diagnosis word captured at frame start |
| ctrl_word | output | 16 | Control word written at frame end |

## Verification
The hardest case to reach is a frame that runs past 16 clocks. Only then do bits received earlier come back out on the data output, and the committed word becomes the later half of the stream. The bench sends a 32-clock frame with two unrelated halves and checks every output bit against that stream. A second directed frame pauses in the middle with the serial clock held low and the select line still asserted, as a byte-oriented host would do. A third frame changes the diagnosis input after selection to show that the captured word is not affected.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
    localparam int SPI_WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } spi_state_e;
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_shreg.sv
module spi_ctl_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample_en,
    input  logic         shift_en,
    input  logic         din,
    output logic         dout,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_q;
    logic         smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            smp_q <= 1'b0;
        end else begin
            if (sample_en) smp_q <= din;
            if (load)          sh_q <= load_val;
            else if (shift_en) sh_q <= {sh_q[W-2:0], smp_q};
        end
    end

    assign dout = sh_q[W-1];
    assign word = sh_q;

    assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(load_val[W-1]));

    assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> word[W-1:1] == $past(word[W-2:0]));
endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
    import spi_ctl_pkg::*;
#(
    parameter int          WORD_W       = SPI_WORD_W,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [WORD_W-1:0] CTRL_DEFAULT = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              defaults_req,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [WORD_W-1:0] diag_word,
    output logic [WORD_W-1:0] ctrl_word
);
    localparam int IN_W = 3;

    logic [IN_W-1:0] pins_s;
    logic            cs_s, sclk_s, mosi_s;
    logic            cs_q, sclk_q;
    logic            cs_fall, cs_rise, sclk_rise, sclk_fall;

    spi_ctl_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_mosi}),
        .q     (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    assign cs_fall   =  cs_q   & ~cs_s;
    assign cs_rise   = ~cs_q   &  cs_s;
    assign sclk_rise = ~sclk_q &  sclk_s;
    assign sclk_fall =  sclk_q & ~sclk_s;

    spi_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = cs_fall ? ST_SHIFT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    logic load_en, sample_en, shift_en, commit_en, oe;

    always_comb begin
        load_en   = 1'b0;
        sample_en = 1'b0;
        shift_en  = 1'b0;
        commit_en = 1'b0;
        oe        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en = cs_fall;
            end
            ST_SHIFT: begin
                oe        = 1'b1;
                sample_en = sclk_rise;
                shift_en  = sclk_fall;
            end
            ST_COMMIT: begin
                commit_en = 1'b1;
                load_en   = cs_fall;
            end
            default: ;
        endcase
    end

    logic [WORD_W-1:0] shift_word;
    logic              shift_out;

    spi_ctl_shreg #(.W(WORD_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_en),
        .load_val  (diag_word),
        .sample_en (sample_en),
        .shift_en  (shift_en),
        .din       (mosi_s),
        .dout      (shift_out),
        .word      (shift_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ctrl_word <= CTRL_DEFAULT;
        else if (defaults_req) ctrl_word <= CTRL_DEFAULT;
        else if (commit_en)    ctrl_word <= shift_word;
    end

    assign spi_miso    = shift_out;
    assign spi_miso_oe = oe;

    assert_quiet_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !spi_miso_oe);

    assert_commit_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && !defaults_req) |=> ctrl_word == $past(shift_word));

    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(state_q == ST_COMMIT) && !$past(defaults_req)) |-> $stable(ctrl_word));

    assert_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        defaults_req |=> ctrl_word == CTRL_DEFAULT);
endmodule

// File: tb/spi_ctl_slave_tb.sv
module spi_ctl_slave_tb;
    localparam int          HALF = 8;
    localparam logic [15:0] DEF  = 16'h0100;

    typedef struct packed {
        logic [15:0] diag;
        logic [15:0] din;
        logic [15:0] exp_ctrl;
    } frame_vec_t;

    localparam frame_vec_t VECS [6] = '{
        '{16'hA5C3, 16'h1234, 16'h1234},
        '{16'h0000, 16'hFFFF, 16'hFFFF},
        '{16'hFFFF, 16'h0000, 16'h0000},
        '{16'h8001, 16'h8001, 16'h8001},
        '{16'h5A5A, 16'hC0DE, 16'hC0DE},
        '{16'h7FFE, 16'h0100, 16'h0100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        defaults_req = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [15:0] diag_word = '0;
    logic [15:0] ctrl_word;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_ctl_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .defaults_req (defaults_req),
        .spi_cs_n     (spi_cs_n),
        .spi_sclk     (spi_sclk),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .spi_miso_oe  (spi_miso_oe),
        .diag_word    (diag_word),
        .ctrl_word    (ctrl_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // stream: bit sent k is stream[31-k]
    task automatic frame(input logic [15:0] diag_v, input logic [31:0] stream,
                         input int nbits, input int gap_at, input bit flip,
                         input logic [15:0] exp_ctrl, input string tag);
        logic [15:0] prev_ctrl;
        logic        exp_bit;
        prev_ctrl = ctrl_word;
        diag_word = diag_v;
        spi_cs_n  = 1'b0;
        wait_n(HALF);
        if (flip) diag_word = ~diag_v;
        for (int k = 0; k < nbits; k++) begin
            spi_mosi = stream[31-k];
            if (k == gap_at) wait_n(5 * HALF);
            wait_n(HALF);
            exp_bit = (k < 16) ? diag_v[15-k] : stream[31-(k-16)];
            check({tag, " R4 miso bit"}, {31'd0, spi_miso}, {31'd0, exp_bit});
            check("R2 oe in frame", {31'd0, spi_miso_oe}, 32'd1);
            if (k == 8) check("R6 ctrl held mid-frame", {16'd0, ctrl_word}, {16'd0, prev_ctrl});
            spi_sclk = 1'b1;
            wait_n(HALF);
            spi_sclk = 1'b0;
        end
        wait_n(HALF);
        check("R6 ctrl held before deselect", {16'd0, ctrl_word}, {16'd0, prev_ctrl});
        spi_cs_n = 1'b1;
        wait_n(HALF);
        check({tag, " R5 ctrl after deselect"}, {16'd0, ctrl_word}, {16'd0, exp_ctrl});
        check("R2 oe after deselect", {31'd0, spi_miso_oe}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        check("R1 reset ctrl", {16'd0, ctrl_word}, {16'd0, DEF});
        check("R1 reset oe", {31'd0, spi_miso_oe}, 32'd0);

        for (int v = 0; v < 6; v++)
            frame(VECS[v].diag, {VECS[v].din, 16'h0}, 16, -1, 1'b0, VECS[v].exp_ctrl, "R3");

        // R7: 32-clock frame, earlier bits return on the output
        frame(16'h9C6B, 32'hDEAD_3E17, 32, -1, 1'b0, 16'h3E17, "R7");

        // R8: two byte bursts with a pause, select held low
        frame(16'h4BD2, {16'hB00F, 16'h0}, 16, 8, 1'b0, 16'hB00F, "R8");

        // R10: diagnosis input changes after selection
        frame(16'hF00D, {16'h6A95, 16'h0}, 16, -1, 1'b1, 16'h6A95, "R10");

        // R9: restore defaults
        @(negedge clk);
        defaults_req = 1'b1;
        @(negedge clk);
        defaults_req = 1'b0;
        check("R9 defaults restored", {16'd0, ctrl_word}, {16'd0, DEF});
        wait_n(HALF);
        check("R2 oe idle", {31'd0, spi_miso_oe}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule